// File: doc/BRIEF.md
# Per-Processor Interrupt Presentation Unit

This unit sits beside one processor and decides whether that processor should be interrupted. It holds three pieces of state. The first is the processor's current priority threshold. The second is an inter-processor request byte. The third is the outcome of the last acceptance. A single device request arrives from the source side as a level: a 24-bit source number and an 8-bit priority, held until the unit acknowledges it. Numerically lower priorities are more favoured. A candidate is presented only when its priority is strictly below the threshold.

Software drives the unit through three kinds of register access:

- An acceptance read returns a 32-bit word. The top byte is the threshold that was in force before the read. The low 24 bits are the accepted source number, or 0 if nothing was deliverable. The read also raises the threshold to the accepted priority.
- A 32-bit end-of-interrupt write restores the threshold from the top byte of the written word.
- Byte writes set the threshold directly, or post a self-interrupt at a chosen priority. That self-interrupt appears as one fixed, reserved source number.

Top module: `irq_presenter`

## Requirements
- R1: After reset the threshold is 0x00, the inter-processor byte is 0xFF (idle), `irq_o` and `dev_ack` are low, and an acceptance read returns 0x00000000.
- R2: `irq_o` is high one cycle after the winning candidate has a priority numerically strictly less than the threshold, and low one cycle after it does not.
- R3: A threshold byte write loads `wdata[7:0]`. With 0xFF every priority below 0xFF is presented. With 0x00 nothing is presented.
- R4: An acceptance read while a candidate is deliverable returns `{old threshold, source}` on `rd_data`, with `rd_valid` high, in the cycle after the strobe. The threshold becomes the accepted priority.
- R5: An acceptance read with nothing deliverable returns `{threshold, 24'h0}` and leaves the threshold unchanged.
- R6: An end-of-interrupt write loads the threshold from `wdata[31:24]`. An acceptance read in the same cycle takes precedence.
- R7: An inter-processor byte write loads `wdata[7:0]`. The value 0xFF means no request. Any other value is a request at that priority, presented as source number `IPI_SRC` (default 2).
- R8: When both a device request and the inter-processor request are live, the lower priority value wins. On equal values the inter-processor request wins.
- R9: Accepting the inter-processor request does not clear it. It is presented again once the threshold allows, until 0xFF is written to the inter-processor byte.
- R10: `dev_ack` pulses for one cycle, together with `rd_valid`, when a read accepts the device request. It stays low when the read accepts the inter-processor request or returns nothing.
- R11: A device request carrying source number 0 is ignored.
- R12: While a priority-5 device interrupt is being serviced (threshold 5), a priority-4 inter-processor request raises `irq_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dev_req | input | 1 | Device request present (level) |
| dev_src | input | 24 | Device source number |
| dev_prio | input | 8 | Device request priority |
| dev_ack | output | 1 | Device request accepted (one-cycle pulse) |
| acc_rd | input | 1 | Acceptance read strobe |
| eoi_wr | input | 1 | End-of-interrupt write strobe |
| cppr_wr | input | 1 | Threshold byte write strobe |
| qirr_wr | input | 1 | Inter-processor byte write strobe |
| wdata | input | 32 | Write data for all write strobes |
| rd_valid | output | 1 | Acceptance read data valid |
| rd_data | output | 32 | `{prior threshold, source}` from the last read |
| irq_o | output | 1 | Interrupt line to the processor |

## Verification
A wrong threshold shows on `irq_o` one cycle after it is loaded, and in the top byte of the next acceptance read. A sweep of thresholds against device priorities therefore exposes any fault in the comparison. A wrong arbitration choice shows as the wrong source number in the very next read, and as a wrong `dev_ack`. A stale or wrongly cleared inter-processor byte shows as `irq_o` failing to rise or fall after the following end-of-interrupt.

// File: rtl/irqp_pkg.sv
package irqp_pkg;
  localparam int unsigned DEF_SRC_W   = 24;
  localparam int unsigned DEF_PRIO_W  = 8;
  localparam int unsigned DEF_IPI_SRC = 2;

  typedef enum logic [1:0] {
    PICK_NONE = 2'd0,
    PICK_DEV  = 2'd1,
    PICK_IPI  = 2'd2
  } pick_e;
endpackage

// File: rtl/irqp_select.sv
module irqp_select
  import irqp_pkg::*;
#(
  parameter int unsigned SRC_W   = DEF_SRC_W,
  parameter int unsigned PRIO_W  = DEF_PRIO_W,
  parameter int unsigned IPI_SRC = DEF_IPI_SRC
) (
  input  logic [PRIO_W-1:0] cppr,
  input  logic [PRIO_W-1:0] qirr,
  input  logic              dev_req,
  input  logic [SRC_W-1:0]  dev_src,
  input  logic [PRIO_W-1:0] dev_prio,
  output pick_e             pick,
  output logic [PRIO_W-1:0] win_prio,
  output logic [SRC_W-1:0]  win_src,
  output logic              deliver
);
  localparam logic [PRIO_W-1:0] PRIO_OFF = '1;
  localparam logic [SRC_W-1:0]  IPI_NUM  = SRC_W'(IPI_SRC);

  logic dev_live;
  logic ipi_live;

  assign dev_live = dev_req && (dev_src != '0);
  assign ipi_live = (qirr != PRIO_OFF);

  // The inter-processor request wins ties against the device.
  always_comb begin
    if (ipi_live && (!dev_live || (qirr <= dev_prio))) begin
      pick     = PICK_IPI;
      win_prio = qirr;
      win_src  = IPI_NUM;
    end else if (dev_live) begin
      pick     = PICK_DEV;
      win_prio = dev_prio;
      win_src  = dev_src;
    end else begin
      pick     = PICK_NONE;
      win_prio = PRIO_OFF;
      win_src  = '0;
    end
  end

  assign deliver = (pick != PICK_NONE) && (win_prio < cppr);
endmodule

// File: rtl/irqp_regs.sv
module irqp_regs #(
  parameter int unsigned PRIO_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_rd,
  input  logic              deliver,
  input  logic [PRIO_W-1:0] take_prio,
  input  logic              eoi_wr,
  input  logic [PRIO_W-1:0] eoi_prio,
  input  logic              cppr_wr,
  input  logic              qirr_wr,
  input  logic [PRIO_W-1:0] byte_val,
  output logic [PRIO_W-1:0] cppr,
  output logic [PRIO_W-1:0] qirr
);
  // Threshold: an acceptance read blocks any other update in the same cycle.
  always_ff @(posedge clk) begin
    if (rst) begin
      cppr <= '0;
    end else if (acc_rd) begin
      if (deliver) cppr <= take_prio;
    end else if (eoi_wr) begin
      cppr <= eoi_prio;
    end else if (cppr_wr) begin
      cppr <= byte_val;
    end
  end

  // The inter-processor byte changes only on its own write.
  always_ff @(posedge clk) begin
    if (rst) begin
      qirr <= '1;
    end else if (qirr_wr) begin
      qirr <= byte_val;
    end
  end
endmodule

// File: rtl/irq_presenter.sv
module irq_presenter
  import irqp_pkg::*;
#(
  parameter int unsigned SRC_W   = DEF_SRC_W,
  parameter int unsigned PRIO_W  = DEF_PRIO_W,
  parameter int unsigned IPI_SRC = DEF_IPI_SRC,
  localparam int unsigned WORD_W = SRC_W + PRIO_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dev_req,
  input  logic [SRC_W-1:0]  dev_src,
  input  logic [PRIO_W-1:0] dev_prio,
  output logic              dev_ack,
  input  logic              acc_rd,
  input  logic              eoi_wr,
  input  logic              cppr_wr,
  input  logic              qirr_wr,
  input  logic [WORD_W-1:0] wdata,
  output logic              rd_valid,
  output logic [WORD_W-1:0] rd_data,
  output logic              irq_o
);
  logic [PRIO_W-1:0] cppr_q;
  logic [PRIO_W-1:0] qirr_q;
  pick_e             pick;
  logic [PRIO_W-1:0] win_prio;
  logic [SRC_W-1:0]  win_src;
  logic              deliver;

  irqp_select #(
    .SRC_W  (SRC_W),
    .PRIO_W (PRIO_W),
    .IPI_SRC(IPI_SRC)
  ) u_select (
    .cppr    (cppr_q),
    .qirr    (qirr_q),
    .dev_req (dev_req),
    .dev_src (dev_src),
    .dev_prio(dev_prio),
    .pick    (pick),
    .win_prio(win_prio),
    .win_src (win_src),
    .deliver (deliver)
  );

  irqp_regs #(
    .PRIO_W(PRIO_W)
  ) u_regs (
    .clk      (clk),
    .rst      (rst),
    .acc_rd   (acc_rd),
    .deliver  (deliver),
    .take_prio(win_prio),
    .eoi_wr   (eoi_wr),
    .eoi_prio (wdata[WORD_W-1 -: PRIO_W]),
    .cppr_wr  (cppr_wr),
    .qirr_wr  (qirr_wr),
    .byte_val (wdata[PRIO_W-1:0]),
    .cppr     (cppr_q),
    .qirr     (qirr_q)
  );

  // Registered outputs toward the processor and the source side.
  always_ff @(posedge clk) begin
    if (rst) begin
      irq_o    <= 1'b0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
      dev_ack  <= 1'b0;
    end else begin
      irq_o    <= deliver;
      rd_valid <= acc_rd;
      dev_ack  <= acc_rd && deliver && (pick == PICK_DEV);
      if (acc_rd) begin
        rd_data <= {cppr_q, (deliver ? win_src : {SRC_W{1'b0}})};
      end
    end
  end
endmodule

// File: rtl/irqp_checker.sv
module irqp_checker #(
  parameter int unsigned SRC_W  = 24,
  parameter int unsigned PRIO_W = 8,
  localparam int unsigned WORD_W = SRC_W + PRIO_W
) (
  input logic              clk,
  input logic              rst,
  input logic              acc_rd,
  input logic              eoi_wr,
  input logic [WORD_W-1:0] wdata,
  input logic              rd_valid,
  input logic [WORD_W-1:0] rd_data,
  input logic              dev_ack,
  input logic [PRIO_W-1:0] cppr_q
);
  AST_READ_ANSWERS: assert property (@(posedge clk) disable iff (rst) acc_rd |=> rd_valid); // R4
  AST_READ_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst) rd_valid |-> $past(acc_rd)); // R4
  AST_TAKE_RAISES: assert property (@(posedge clk) disable iff (rst) (rd_valid && rd_data[SRC_W-1:0] != '0) |-> (rd_data[WORD_W-1 -: PRIO_W] == $past(cppr_q) && cppr_q < $past(cppr_q))); // R4
  AST_SPURIOUS_KEEPS: assert property (@(posedge clk) disable iff (rst) (rd_valid && rd_data[SRC_W-1:0] == '0) |-> (cppr_q == $past(cppr_q))); // R5
  AST_EOI_LOADS: assert property (@(posedge clk) disable iff (rst) $past(eoi_wr && !acc_rd && !rst) |-> (cppr_q == $past(wdata[WORD_W-1 -: PRIO_W]))); // R6
  AST_ACK_WITH_READ: assert property (@(posedge clk) disable iff (rst) dev_ack |-> (rd_valid && rd_data[SRC_W-1:0] != '0)); // R10
endmodule

bind irq_presenter irqp_checker #(
  .SRC_W (SRC_W),
  .PRIO_W(PRIO_W)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .acc_rd  (acc_rd),
  .eoi_wr  (eoi_wr),
  .wdata   (wdata),
  .rd_valid(rd_valid),
  .rd_data (rd_data),
  .dev_ack (dev_ack),
  .cppr_q  (cppr_q)
);

// File: tb/irq_presenter_test.sv
`timescale 1ns/1ps
module irq_presenter_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        dev_req = 1'b0;
  logic [23:0] dev_src = '0;
  logic [7:0]  dev_prio = '0;
  logic        dev_ack;
  logic        acc_rd = 1'b0;
  logic        eoi_wr = 1'b0;
  logic        cppr_wr = 1'b0;
  logic        qirr_wr = 1'b0;
  logic [31:0] wdata = '0;
  logic        rd_valid;
  logic [31:0] rd_data;
  logic        irq_o;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  irq_presenter uut (
    .clk(clk), .rst(rst), .dev_req(dev_req), .dev_src(dev_src),
    .dev_prio(dev_prio), .dev_ack(dev_ack), .acc_rd(acc_rd),
    .eoi_wr(eoi_wr), .cppr_wr(cppr_wr), .qirr_wr(qirr_wr),
    .wdata(wdata), .rd_valid(rd_valid), .rd_data(rd_data), .irq_o(irq_o)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic set_cppr(input logic [7:0] v);
    cppr_wr = 1'b1; wdata = {24'h0, v}; tick(); cppr_wr = 1'b0;
  endtask

  task automatic set_qirr(input logic [7:0] v);
    qirr_wr = 1'b1; wdata = {24'h0, v}; tick(); qirr_wr = 1'b0;
  endtask

  task automatic eoi(input logic [31:0] v);
    eoi_wr = 1'b1; wdata = v; tick(); eoi_wr = 1'b0;
  endtask

  // Returns data and ack as seen in the cycle after the strobe.
  task automatic do_read(output logic [31:0] d, output logic ack, output logic vld);
    acc_rd = 1'b1; tick(); acc_rd = 1'b0;
    d = rd_data; ack = dev_ack; vld = rd_valid;
  endtask

  initial begin
    #200us;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic ack, vld;
    logic [23:0] exp_src;

    // R1: reset state; a priority-0 device request must stay hidden behind threshold 0
    dev_req = 1'b1; dev_prio = 8'h00; dev_src = 24'h000009;
    repeat (3) tick();
    rst = 1'b0;
    tick();
    chk("R1 irq after reset", {31'h0, irq_o}, 32'h0);
    chk("R1 ack after reset", {31'h0, dev_ack}, 32'h0);
    do_read(d, ack, vld);
    chk("R1 read after reset", d, 32'h0000_0000);
    chk("R1 read valid", {31'h0, vld}, 32'h1);
    chk("R10 no ack on empty read", {31'h0, ack}, 32'h0);
    dev_req = 1'b0;

    // R2/R3: sweep threshold against device priority
    for (int c = 0; c <= 16; c++) begin
      for (int p = 0; p < 16; p++) begin
        logic [7:0] cv;
        cv = (c == 16) ? 8'hFF : 8'(c);
        dev_req = 1'b1; dev_prio = 8'(p); dev_src = 24'h000777;
        set_cppr(cv);
        tick();
        chk($sformatf("R2 R3 irq cppr=%0h prio=%0h", cv, p), {31'h0, irq_o},
            {31'h0, (8'(p) < cv)});
      end
    end
    dev_req = 1'b0;

    // R11: source 0 ignored
    set_cppr(8'hFF);
    dev_req = 1'b1; dev_prio = 8'h03; dev_src = 24'h0;
    tick(); tick();
    chk("R11 irq with source 0", {31'h0, irq_o}, 32'h0);
    do_read(d, ack, vld);
    chk("R11 read with source 0", d, 32'hFF00_0000);
    dev_req = 1'b0;

    // R7/R8/R10: arbitration sweep, IPI source number 2
    for (int q = 0; q < 8; q++) begin
      for (int dp = 0; dp < 8; dp++) begin
        eoi(32'hFF00_0000);
        set_qirr(8'(q));
        dev_req = 1'b1; dev_prio = 8'(dp); dev_src = 24'h000100 | 24'(dp);
        exp_src = (q <= dp) ? 24'h000002 : (24'h000100 | 24'(dp));
        do_read(d, ack, vld);
        chk($sformatf("R8 R7 pick q=%0d d=%0d", q, dp), d, {8'hFF, exp_src});
        chk($sformatf("R10 ack q=%0d d=%0d", q, dp), {31'h0, ack}, {31'h0, (q > dp)});
        dev_req = 1'b0;
        set_qirr(8'hFF);
      end
    end

    // R4/R10/R12/R9/R6/R5: nested service sequence
    eoi(32'hFF00_0000);
    dev_req = 1'b1; dev_prio = 8'h05; dev_src = 24'h000055;
    tick();
    do_read(d, ack, vld);
    chk("R4 device accept word", d, 32'hFF00_0055);
    chk("R10 device ack", {31'h0, ack}, 32'h1);
    dev_req = 1'b0;
    tick();
    chk("R10 ack one cycle", {31'h0, dev_ack}, 32'h0);
    chk("R4 irq drops after accept", {31'h0, irq_o}, 32'h0);
    set_qirr(8'h04);
    tick();
    chk("R12 ipi preempts device", {31'h0, irq_o}, 32'h1);
    do_read(d, ack, vld);
    chk("R4 ipi accept word", d, 32'h0500_0002);
    chk("R10 no ack on ipi", {31'h0, ack}, 32'h0);
    tick();
    chk("R4 irq drops after ipi accept", {31'h0, irq_o}, 32'h0);
    eoi(32'h0500_0002);
    tick();
    chk("R9 ipi presented again", {31'h0, irq_o}, 32'h1);
    set_qirr(8'hFF);
    tick();
    chk("R7 ipi cleared by FF", {31'h0, irq_o}, 32'h0);
    eoi(32'hFF00_0055);
    do_read(d, ack, vld);
    chk("R6 eoi restored threshold", d, 32'hFF00_0000);
    do_read(d, ack, vld);
    chk("R5 empty read keeps threshold", d, 32'hFF00_0000);

    // R6: eoi to an intermediate threshold
    eoi(32'h0300_0ABC);
    dev_req = 1'b1; dev_prio = 8'h03; dev_src = 24'h000031;
    tick(); tick();
    chk("R6 equal priority blocked", {31'h0, irq_o}, 32'h0);
    dev_prio = 8'h02;
    tick(); tick();
    chk("R6 lower priority presented", {31'h0, irq_o}, 32'h1);
    do_read(d, ack, vld);
    chk("R4 word after eoi", d, 32'h0300_0031);
    dev_req = 1'b0;

    // R3: threshold 0 rejects everything
    set_cppr(8'h00);
    set_qirr(8'h00);
    tick();
    chk("R3 threshold 0 rejects ipi", {31'h0, irq_o}, 32'h0);
    set_qirr(8'hFF);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule